// File: doc/BRIEF.md
# Port Transmit Rate Shaper

This block paces the traffic of one output port by keeping a running debt. Every packet that begins adds a per-packet cost, scaled up by 256. Every 64-bit data word that moves adds a per-word cost, which is not scaled. The debt drains by 16 tokens on each clock and never drops below zero. A single `may_send` output tells the packet scheduler whether it may start a new packet. It is high while the debt does not exceed the burst limit, which is also scaled up by 256. The block only gates packet starts. A packet that has already begun keeps charging words until it ends.

Software works out the three settings from the clock frequency and the target rate. For bit-rate shaping the packet cost covers 24 bytes of line overhead: 12 bytes of gap, 8 bytes of preamble and 4 bytes of CRC. For packet-rate shaping the word cost is set to zero. All three settings are written together in one cycle, and that write also clears the debt. The debt register saturates at its maximum value and never wraps.

Top module: `port_rate_shaper`

## Requirements
- R1: After reset the debt is zero and every setting is zero, so `may_send` is 1.
- R2: A cycle with `pkt_start` high adds 256 × packet cost to the debt, that is, the cost shifted left by 8 bits.
- R3: A cycle with `word_valid` high adds the word cost to the debt, unscaled. When both strobes are high in the same cycle, both charges are added.
- R4: On every clock without a settings write, the debt falls by 16 after any charge is added, and it stops at zero.
- R5: `may_send` is 1 exactly when the registered debt is ≤ 256 × limit. It is a combinational function of registered state.
- R6: The debt saturates at 2^DEBT_W − 1 before the drain is applied, and it never wraps to a small value.
- R7: A cycle with `cfg_we` high loads all three settings and sets the debt to zero. Any strobe in that same cycle is ignored.
- R8: With a word cost of zero, word strobes leave the debt unchanged and so never lower `may_send`. Packet starts still charge the debt.
- R9: A charge and the drain happen in the same clock: next debt = max(min(debt + charges, max) − 16, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Settings write strobe; also clears the debt |
| cfg_pkt_cost | input | PKT_COST_W | Per-packet cost, in units of 256 tokens |
| cfg_word_cost | input | WORD_COST_W | Per-word cost, in tokens |
| cfg_limit | input | LIMIT_W | Burst limit, in units of 256 tokens |
| pkt_start | input | 1 | High for one cycle when a packet begins |
| word_valid | input | 1 | High for each 64-bit word sent |
| may_send | output | 1 | High when a new packet may be started |

## Verification
Assertions check four rules on every cycle:
- A settings write leaves the debt at zero.
- An idle cycle lowers the debt by exactly 16, or to zero.
- A charged cycle moves the debt by the charge minus 16, unless the result saturates or bottoms out at zero.
- `may_send` only rises when the debt falls or the settings change.

Other behaviour can only be shown by the bench's scenarios:
- The 256× scale of packet charges against word charges.
- The exact cycle on which the limit comparison flips.
- The saturation point, found by timing how long the port takes to reopen.
- The effect of a zero word cost.

The bench's reference model follows these scenarios and a pseudo-random strobe pattern cycle by cycle.

// File: rtl/rate_shaper_pkg.sv
package rate_shaper_pkg;
    // Packet cost and limit are this many bits coarser than word cost.
    localparam int COARSE_SHIFT  = 8;
    // Tokens that leak out of the debt on every clock.
    localparam int DRAIN_PER_CLK = 16;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/shaper_cfg.sv
module shaper_cfg #(
    parameter int PKT_W  = 24,
    parameter int WORD_W = 24,
    parameter int LIM_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PKT_W-1:0]  pkt_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LIM_W-1:0]  lim_in,
    output logic [PKT_W-1:0]  pkt_cost,
    output logic [WORD_W-1:0] word_cost,
    output logic [LIM_W-1:0]  limit
);
    typedef struct packed {
        logic [PKT_W-1:0]  pkt;
        logic [WORD_W-1:0] word;
        logic [LIM_W-1:0]  lim;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.pkt  = pkt_in;
            cfg_d.word = word_in;
            cfg_d.lim  = lim_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pkt_cost  = cfg_q.pkt;
    assign word_cost = cfg_q.word;
    assign limit     = cfg_q.lim;
endmodule

// File: rtl/shaper_charge.sv
module shaper_charge
    import rate_shaper_pkg::*;
#(
    parameter int PKT_W  = 24,
    parameter int WORD_W = 24,
    parameter int CHG_W  = 33
) (
    input  logic              pkt_start,
    input  logic              word_valid,
    input  logic [PKT_W-1:0]  pkt_cost,
    input  logic [WORD_W-1:0] word_cost,
    output logic [CHG_W-1:0]  charge
);
    logic [CHG_W-1:0] pkt_part, word_part;

    always_comb begin
        pkt_part  = pkt_start  ? CHG_W'({pkt_cost, {COARSE_SHIFT{1'b0}}}) : '0;
        word_part = word_valid ? CHG_W'(word_cost) : '0;
        charge    = pkt_part + word_part;
    end
endmodule

// File: rtl/shaper_debt.sv
module shaper_debt
    import rate_shaper_pkg::*;
#(
    parameter int DEBT_W = 40,
    parameter int CHG_W  = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [CHG_W-1:0]  charge,
    output logic [DEBT_W-1:0] debt
);
    localparam int SUM_W  = max2(DEBT_W, CHG_W) + 1;
    localparam int WIDE_W = SUM_W + 1;
    localparam logic [DEBT_W-1:0] MAX_V   = {DEBT_W{1'b1}};
    localparam logic [DEBT_W-1:0] DRAIN_V = DEBT_W'(DRAIN_PER_CLK);

    typedef logic [WIDE_W-1:0] wide_t;
    typedef struct packed {
        logic [DEBT_W-1:0] debt;
    } st_t;

    st_t st_d, st_q;
    logic [SUM_W-1:0]  sum;
    logic [DEBT_W-1:0] capped;

    always_comb begin
        st_d   = st_q;
        sum    = SUM_W'(st_q.debt) + SUM_W'(charge);
        capped = (sum > SUM_W'(MAX_V)) ? MAX_V : sum[DEBT_W-1:0];
        st_d.debt = (capped >= DRAIN_V) ? (capped - DRAIN_V) : '0;
        if (clear) st_d.debt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign debt = st_q.debt;

    // R7: a settings write leaves no debt behind
    assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (debt == '0));

    // R4: an uncharged cycle drains exactly 16 or reaches zero
    assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && charge == '0) |=>
        (debt == (($past(debt) >= DRAIN_V) ? ($past(debt) - DRAIN_V) : '0)));

    // R6: a charged cycle never lets the debt fall by more than the drain
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && charge != '0) |=>
        (wide_t'(debt) + wide_t'(DRAIN_V) >= wide_t'($past(debt))));

    // R9: charge and drain combine in one clock
    assert_charge_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && charge != '0) |=>
        ((debt == MAX_V - DRAIN_V) || (debt == '0) ||
         (wide_t'(debt) + wide_t'(DRAIN_V) ==
          wide_t'($past(debt)) + wide_t'($past(charge)))));
endmodule

// File: rtl/shaper_gate.sv
module shaper_gate
    import rate_shaper_pkg::*;
#(
    parameter int DEBT_W = 40,
    parameter int LIM_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEBT_W-1:0] debt,
    input  logic [LIM_W-1:0]  limit,
    output logic              may_send
);
    localparam int CMP_W = max2(DEBT_W, LIM_W + COARSE_SHIFT);

    logic [CMP_W-1:0] thresh;

    always_comb begin
        thresh   = CMP_W'({limit, {COARSE_SHIFT{1'b0}}});
        may_send = (CMP_W'(debt) <= thresh);
    end

    // R5: the port only reopens when debt falls or the limit changes
    assert_open_on_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(may_send) |-> ((debt < $past(debt)) || (limit != $past(limit))));
endmodule

// File: rtl/port_rate_shaper.sv
module port_rate_shaper
    import rate_shaper_pkg::*;
#(
    parameter int DEBT_W      = 40,
    parameter int PKT_COST_W  = 24,
    parameter int WORD_COST_W = 24,
    parameter int LIMIT_W     = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [PKT_COST_W-1:0]  cfg_pkt_cost,
    input  logic [WORD_COST_W-1:0] cfg_word_cost,
    input  logic [LIMIT_W-1:0]     cfg_limit,
    input  logic                   pkt_start,
    input  logic                   word_valid,
    output logic                   may_send
);
    localparam int CHG_W = max2(PKT_COST_W + COARSE_SHIFT, WORD_COST_W) + 1;

    logic [PKT_COST_W-1:0]  pkt_cost;
    logic [WORD_COST_W-1:0] word_cost;
    logic [LIMIT_W-1:0]     limit;
    logic [CHG_W-1:0]       charge;
    logic [DEBT_W-1:0]      debt;

    shaper_cfg #(.PKT_W(PKT_COST_W), .WORD_W(WORD_COST_W), .LIM_W(LIMIT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we),
        .pkt_in(cfg_pkt_cost), .word_in(cfg_word_cost), .lim_in(cfg_limit),
        .pkt_cost(pkt_cost), .word_cost(word_cost), .limit(limit)
    );

    shaper_charge #(.PKT_W(PKT_COST_W), .WORD_W(WORD_COST_W), .CHG_W(CHG_W)) u_charge (
        .pkt_start(pkt_start), .word_valid(word_valid),
        .pkt_cost(pkt_cost), .word_cost(word_cost), .charge(charge)
    );

    shaper_debt #(.DEBT_W(DEBT_W), .CHG_W(CHG_W)) u_debt (
        .clk(clk), .rst_n(rst_n), .clear(cfg_we), .charge(charge), .debt(debt)
    );

    shaper_gate #(.DEBT_W(DEBT_W), .LIM_W(LIMIT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .debt(debt), .limit(limit), .may_send(may_send)
    );
endmodule

// File: tb/test_port_rate_shaper.sv
`timescale 1ns/1ps
module test_port_rate_shaper;
    localparam int DW = 20, PW = 12, WW = 12, LW = 12;
    localparam longint M_MAX = (longint'(1) << DW) - 1;

    logic clk = 0, rst_n = 0, cfg_we = 0, pkt_start = 0, word_valid = 0;
    logic [PW-1:0] cfg_pkt_cost = '0;
    logic [WW-1:0] cfg_word_cost = '0;
    logic [LW-1:0] cfg_limit = '0;
    logic may_send;

    int n_tests = 0, n_fail = 0;
    bit cmp_en = 0, done = 0;
    string cur_req = "R1";
    longint m_debt = 0, m_pkt = 0, m_word = 0, m_lim = 0;

    always #2.5 clk = ~clk;

    port_rate_shaper #(.DEBT_W(DW), .PKT_COST_W(PW), .WORD_COST_W(WW), .LIMIT_W(LW)) i_port_rate_shaper (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pkt_cost(cfg_pkt_cost),
        .cfg_word_cost(cfg_word_cost), .cfg_limit(cfg_limit),
        .pkt_start(pkt_start), .word_valid(word_valid), .may_send(may_send)
    );

    // Behavioural reference: token debt as a plain integer
    always @(posedge clk) begin
        longint s;
        if (!rst_n) begin
            m_debt = 0; m_pkt = 0; m_word = 0; m_lim = 0;
        end else if (cfg_we) begin
            m_pkt = cfg_pkt_cost; m_word = cfg_word_cost; m_lim = cfg_limit; m_debt = 0;
        end else begin
            s = m_debt + (pkt_start ? m_pkt * 256 : 0) + (word_valid ? m_word : 0);
            if (s > M_MAX) s = M_MAX;
            m_debt = (s >= 16) ? s - 16 : 0;
        end
    end

    always @(negedge clk) begin
        logic exp;
        if (cmp_en) begin
            exp = (m_debt <= m_lim * 256);
            n_tests++;
            if (may_send !== exp) begin
                n_fail++;
                $display("FAIL %s model: may_send=%0b expected %0b", cur_req, may_send, exp);
            end
        end
    end

    task automatic chk(input string req, input logic exp);
        n_tests++;
        if (may_send !== exp) begin
            n_fail++;
            $display("FAIL %s: may_send=%0b expected %0b", req, may_send, exp);
        end
    endtask

    task automatic cyc(input logic ps, input logic wv);
        pkt_start = ps; word_valid = wv;
        @(negedge clk);
        pkt_start = 0; word_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input int p, input int w, input int l);
        cfg_we = 1; cfg_pkt_cost = PW'(p); cfg_word_cost = WW'(w); cfg_limit = LW'(l);
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        logic [7:0] lfsr;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
        chk("R1", 1'b1);

        cur_req = "R7"; cfg(2, 4, 1);           // threshold 256
        chk("R7", 1'b1);
        cur_req = "R2"; cyc(1, 0);              // 512-16 = 496
        chk("R2", 1'b0);
        cur_req = "R4"; idle(14);               // 272
        chk("R4", 1'b0);
        idle(1);                                // 256, equal to threshold
        chk("R4", 1'b1);
        idle(20);

        cur_req = "R3"; cfg(2, 100, 1);         // +84 net per word
        cyc(0, 1); cyc(0, 1); cyc(0, 1);        // 252
        chk("R3", 1'b1);
        cyc(0, 1);                              // 336
        chk("R3", 1'b0);
        idle(30);

        cur_req = "R8"; cfg(2, 0, 0);           // threshold 0
        for (int i = 0; i < 10; i++) cyc(0, 1);
        chk("R8", 1'b1);
        cyc(1, 1);
        chk("R8", 1'b0);
        idle(40);

        cur_req = "R9"; cfg(1, 40, 1);
        cyc(1, 1);                              // 256+40-16 = 280
        chk("R9", 1'b0);
        idle(1);                                // 264
        chk("R9", 1'b0);
        idle(1);                                // 248
        chk("R9", 1'b1);

        cur_req = "R6"; cfg(4095, 4095, 4095);  // threshold 1048320
        cyc(1, 1); cyc(1, 1); cyc(1, 1);        // saturated, then 1048559
        chk("R6", 1'b0);
        idle(14);                               // 1048335
        chk("R6", 1'b0);
        idle(1);                                // 1048319
        chk("R6", 1'b1);

        cur_req = "R7"; cfg(1, 0, 0);
        cyc(1, 0);                              // 240
        chk("R7", 1'b0);
        cfg_we = 1; pkt_start = 1; word_valid = 1;
        @(negedge clk);
        cfg_we = 0; pkt_start = 0; word_valid = 0;
        chk("R7", 1'b1);

        cur_req = "R1"; cyc(1, 0);
        chk("R1", 1'b0);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        chk("R1", 1'b1);

        cur_req = "R5"; cfg(3, 20, 2);
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0] & lfsr[3] & may_send, lfsr[1] | lfsr[2]);
        end
        idle(100);
        chk("R5", 1'b1);

        cmp_en = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule